// File: doc/BRIEF.md
# SAR Converter Serial Command Front-End

This block is the digital control side of a multichannel successive-approximation converter that a host drives over a four-wire serial link. The link uses clock polarity 0 and phase 0. The host lowers the select line and shifts an 8-bit command word in on the data input. The block captures the command, announces the selected channel, and fires a sample strobe at a fixed serial-clock count. It then resolves the 16-bit result one bit per falling serial edge with a bit-serial successive-approximation register. The register presents a trial word to an external comparator, and each decision goes straight out on the data output, most significant bit first. A width-select input, captured when the select line falls, chooses a short frame of 24 clocks or a long frame of 32 clocks. The long frame moves the sample point and the start of the result eight clocks later.

All serial inputs are taken as already synchronous to the fast system clock, and their edges are found by comparing each input with its registered copy. A state machine tracks each frame through five states:
- `ST_DOWN`: select line high, output disabled.
- `ST_TRACK`: select line low, input being tracked.
- `ST_HOLD`: sampled, waiting for the first result clock.
- `ST_SHIFT`: resolving and sending result bits.
- `ST_FLUSH`: result sent, padding with zeros.

The transitions are:
- DOWN→TRACK on a select fall.
- TRACK→HOLD on the sample fall.
- HOLD→SHIFT on the first result fall.
- SHIFT→FLUSH on the sixteenth result fall.
- Any state→DOWN on a select rise, which also aborts a conversion in progress.

In the power-down state, the reference and buffer status outputs follow the committed power field.

Top module: `sar_cmd_frontend`

## Requirements
- R1: After reset the configuration word reads 8'b0000_0110, the channel output reads 0, the data output is disabled and driven 0, and both the reference and buffer status outputs are 0.
- R2: One system clock after the select line is seen falling, `dout_oe` is 1 and `dout` is 0. One clock after it is seen rising, `dout_oe` is 0 and `dout` is 0.
- R3: The command is shifted in MSB first on rising serial edges. Its first three bits (command bits 7:5) appear on `chan_sel` one clock after the 3rd rising edge, together with a one-clock `chan_load` pulse.
- R4: `sample_pulse` fires for one clock after falling serial edge 6 in the short frame, or edge 14 in the long frame. `conv_busy` rises with it and stays high until the final result bit is sent.
- R5: The result is sent MSB first, starting at falling edge 8 (short frame) or 16 (long frame), one bit per falling edge for 16 edges. Each bit is the comparator decision on a trial word that starts at 16'h8000. With an ideal comparator (`cmp_in` = code ≥ trial), the bits equal the input code in straight binary.
- R6: Every falling edge before the first result bit drives `dout` to 0, so the first byte of a short frame reads as zeros.
- R7: Falling edges after the last result bit, while the select line stays low, drive `dout` to 0.
- R8: A select rise during a conversion drops `conv_busy` at once, sends no further result bits, and returns the block to the power-down state.
- R9: The full command word (bits 7:5 channel, 4:3 scan, 2:1 power, 0 clock source) is committed to `cfg_word` on the 8th rising serial edge. A frame that ends before that edge leaves `cfg_word` unchanged.
- R10: In the power-down state the status outputs decode `cfg_word[2:1]`:
  - 00 gives reference and buffer on.
  - 01 gives both off.
  - 10 gives reference on and buffer off.
  - 11 gives both off.
  
  While the select line is low, both are on unless the field is 11.
- R11: `wide_sel` is captured at the select fall (1 = 32-clock frame), and changes to it during a frame have no effect on that frame's timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial link |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low frame select |
| sclk | input | 1 | Serial clock, idle low |
| din | input | 1 | Serial command data, MSB first |
| wide_sel | input | 1 | Frame width select, 1 = 32-clock frame |
| cmp_in | input | 1 | Comparator decision, 1 when input ≥ trial word |
| dout | output | 1 | Serial result data |
| dout_oe | output | 1 | Output enable for `dout` (0 = high impedance) |
| chan_sel | output | 3 | Selected input channel |
| chan_load | output | 1 | One-clock strobe when `chan_sel` is updated |
| sample_pulse | output | 1 | One-clock strobe at the sample instant |
| conv_busy | output | 1 | High from the sample instant until the last result bit |
| trial | output | 16 | Trial word presented to the comparator |
| cfg_word | output | 8 | Committed configuration word |
| ref_on | output | 1 | Reference powered |
| buf_on | output | 1 | Reference buffer powered |

## Verification
The main function is exercised with frames of both widths and with several codes:
- An alternating-bit code and a mixed code show whether bits come out in order and at the right falling edge.
- The all-ones and all-zeros codes expose stuck decisions.
- The mid-scale code 16'h8000 shows whether the trial word starts at the MSB.

Frames that run past their nominal length separate the trailing-zero behaviour from a repeated result. Frames cut short, before the 8th rising edge and in mid-conversion, separate "configuration untouched" from "conversion aborted". One frame toggles the width select after the select fall, to show that the captured width governs the sample and result points.

// File: rtl/sarfe_pkg.sv
package sarfe_pkg;

    typedef enum logic [2:0] {
        ST_DOWN,
        ST_TRACK,
        ST_HOLD,
        ST_SHIFT,
        ST_FLUSH
    } fe_state_t;

    localparam logic [7:0] CMD_RESET = 8'b0000_0110;

    // Power field encodings (command bits 2:1)
    localparam logic [1:0] PWR_ALL_ON  = 2'b00;
    localparam logic [1:0] PWR_ALL_OFF = 2'b01;
    localparam logic [1:0] PWR_REF_ON  = 2'b10;
    localparam logic [1:0] PWR_EXT_REF = 2'b11;

endpackage

// File: rtl/sarfe_edge.sv
module sarfe_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sclk,
    output logic cs_fall,
    output logic cs_rise,
    output logic sck_rise,
    output logic sck_fall
);
    logic cs_q;
    logic sclk_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q   <= 1'b1;
            sclk_q <= 1'b0;
        end else begin
            cs_q   <= cs_n;
            sclk_q <= sclk;
        end
    end

    always_comb begin
        cs_fall  = cs_q & ~cs_n;
        cs_rise  = ~cs_q & cs_n;
        sck_rise = ~cs_n & sclk & ~sclk_q;
        sck_fall = ~cs_n & ~sclk & sclk_q;
    end

endmodule

// File: rtl/sarfe_cmd.sv
module sarfe_cmd
    import sarfe_pkg::*;
#(
    parameter int CMD_W   = 8,
    parameter int CHAN_W  = 3,
    parameter int CNT_W   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              active,
    input  logic              sck_rise,
    input  logic              din,
    output logic [CHAN_W-1:0] chan_sel,
    output logic              chan_load,
    output logic [CMD_W-1:0]  cfg_word
);
    localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CHAN_AT  = CNT_W'(CHAN_W);
    localparam logic [CNT_W-1:0] COMMIT_AT = CNT_W'(CMD_W);

    logic [CNT_W-1:0] rise_cnt;
    logic [CNT_W-1:0] rise_nxt;
    logic [CMD_W-1:0] shreg;
    logic [CMD_W-1:0] shreg_nxt;

    always_comb begin
        rise_nxt  = (rise_cnt == CNT_MAX) ? rise_cnt : rise_cnt + 1'b1;
        shreg_nxt = {shreg[CMD_W-2:0], din};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rise_cnt  <= '0;
            shreg     <= '0;
            chan_sel  <= '0;
            chan_load <= 1'b0;
            cfg_word  <= CMD_RESET;
        end else begin
            chan_load <= 1'b0;
            if (clear) begin
                rise_cnt <= '0;
            end else if (active && sck_rise) begin
                rise_cnt <= rise_nxt;
                if (rise_nxt <= COMMIT_AT) begin
                    shreg <= shreg_nxt;
                end
                if (rise_nxt == CHAN_AT) begin
                    chan_sel  <= shreg_nxt[CHAN_W-1:0];
                    chan_load <= 1'b1;
                end
                if (rise_nxt == COMMIT_AT) begin
                    cfg_word <= shreg_nxt;
                end
            end
        end
    end

    AST_CHAN_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        chan_load |=> !chan_load); // R3

endmodule

// File: rtl/sarfe_sar.sv
module sarfe_sar #(
    parameter int RES_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             step,
    input  logic             abort,
    input  logic             cmp_in,
    output logic [RES_W-1:0] trial,
    output logic             last
);
    localparam int IDX_W = $clog2(RES_W);
    localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(RES_W - 1);

    logic [RES_W-1:0] res;
    logic [IDX_W-1:0] idx;
    logic             act;
    logic [RES_W-1:0] probe;

    always_comb begin
        probe = act ? (RES_W'(1) << idx) : '0;
        trial = res | probe;
        last  = act && (idx == '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res <= '0;
            idx <= '0;
            act <= 1'b0;
        end else if (abort) begin
            act <= 1'b0;
        end else if (start) begin
            res <= '0;
            idx <= IDX_TOP;
            act <= 1'b1;
        end else if (step && act) begin
            res[idx] <= cmp_in;
            if (idx == '0) begin
                act <= 1'b0;
            end else begin
                idx <= idx - 1'b1;
            end
        end
    end

    AST_SAR_MSB_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !abort) |=> (trial == {1'b1, {(RES_W-1){1'b0}}})); // R5

endmodule

// File: rtl/sarfe_pwr.sv
module sarfe_pwr
    import sarfe_pkg::*;
(
    input  logic       powered_down,
    input  logic [1:0] pwr_field,
    output logic       ref_on,
    output logic       buf_on
);
    always_comb begin
        if (!powered_down) begin
            ref_on = (pwr_field != PWR_EXT_REF);
            buf_on = (pwr_field != PWR_EXT_REF);
        end else begin
            unique case (pwr_field)
                PWR_ALL_ON:  begin ref_on = 1'b1; buf_on = 1'b1; end
                PWR_ALL_OFF: begin ref_on = 1'b0; buf_on = 1'b0; end
                PWR_REF_ON:  begin ref_on = 1'b1; buf_on = 1'b0; end
                default:     begin ref_on = 1'b0; buf_on = 1'b0; end
            endcase
        end
    end

endmodule

// File: rtl/sar_cmd_frontend.sv
module sar_cmd_frontend
    import sarfe_pkg::*;
#(
    parameter int CMD_W  = 8,
    parameter int CHAN_W = 3,
    parameter int RES_W  = 16,
    parameter int CNT_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              din,
    input  logic              wide_sel,
    input  logic              cmp_in,
    output logic              dout,
    output logic              dout_oe,
    output logic [CHAN_W-1:0] chan_sel,
    output logic              chan_load,
    output logic              sample_pulse,
    output logic              conv_busy,
    output logic [RES_W-1:0]  trial,
    output logic [CMD_W-1:0]  cfg_word,
    output logic              ref_on,
    output logic              buf_on
);
    localparam logic [CNT_W-1:0] CNT_MAX      = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] START_NARROW = CNT_W'(CMD_W);
    localparam logic [CNT_W-1:0] START_WIDE   = CNT_W'(2 * CMD_W);
    localparam logic [CNT_W-1:0] SAMP_NARROW  = CNT_W'(CMD_W - 2);
    localparam logic [CNT_W-1:0] SAMP_WIDE    = CNT_W'(2 * CMD_W - 2);

    fe_state_t        state;
    fe_state_t        state_nxt;
    logic             cs_fall, cs_rise, sck_rise, sck_fall;
    logic [CNT_W-1:0] fall_cnt;
    logic [CNT_W-1:0] fall_nxt;
    logic             wide_q;
    logic [CNT_W-1:0] samp_at;
    logic [CNT_W-1:0] start_at;
    logic             sar_start, sar_step, sar_last;

    sarfe_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .sclk     (sclk),
        .cs_fall  (cs_fall),
        .cs_rise  (cs_rise),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall)
    );

    sarfe_cmd #(
        .CMD_W  (CMD_W),
        .CHAN_W (CHAN_W),
        .CNT_W  (CNT_W)
    ) u_cmd (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (cs_fall),
        .active    (state != ST_DOWN),
        .sck_rise  (sck_rise),
        .din       (din),
        .chan_sel  (chan_sel),
        .chan_load (chan_load),
        .cfg_word  (cfg_word)
    );

    sarfe_sar #(
        .RES_W (RES_W)
    ) u_sar (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (sar_start),
        .step   (sar_step),
        .abort  (cs_rise),
        .cmp_in (cmp_in),
        .trial  (trial),
        .last   (sar_last)
    );

    sarfe_pwr u_pwr (
        .powered_down (state == ST_DOWN),
        .pwr_field    (cfg_word[2:1]),
        .ref_on       (ref_on),
        .buf_on       (buf_on)
    );

    always_comb begin
        fall_nxt  = (fall_cnt == CNT_MAX) ? fall_cnt : fall_cnt + 1'b1;
        samp_at   = wide_q ? SAMP_WIDE  : SAMP_NARROW;
        start_at  = wide_q ? START_WIDE : START_NARROW;
        conv_busy = (state == ST_HOLD) || (state == ST_SHIFT);
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_DOWN;
        end else begin
            state <= state_nxt;
        end
    end

    // Next state and conversion controls
    always_comb begin
        state_nxt = state;
        sar_start = 1'b0;
        sar_step  = 1'b0;
        unique case (state)
            ST_DOWN: begin
                if (cs_fall) state_nxt = ST_TRACK;
            end
            ST_TRACK: begin
                if (sck_fall && fall_nxt == samp_at) begin
                    state_nxt = ST_HOLD;
                    sar_start = 1'b1;
                end
            end
            ST_HOLD: begin
                if (sck_fall && fall_nxt == start_at) begin
                    state_nxt = ST_SHIFT;
                    sar_step  = 1'b1;
                end
            end
            ST_SHIFT: begin
                if (sck_fall) begin
                    sar_step = 1'b1;
                    if (sar_last) state_nxt = ST_FLUSH;
                end
            end
            ST_FLUSH: begin
                state_nxt = ST_FLUSH;
            end
            default: state_nxt = ST_DOWN;
        endcase
        if (cs_rise) begin
            state_nxt = ST_DOWN;
            sar_start = 1'b0;
            sar_step  = 1'b0;
        end
    end

    // Registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fall_cnt     <= '0;
            wide_q       <= 1'b0;
            dout         <= 1'b0;
            dout_oe      <= 1'b0;
            sample_pulse <= 1'b0;
        end else if (cs_rise) begin
            dout         <= 1'b0;
            dout_oe      <= 1'b0;
            sample_pulse <= 1'b0;
        end else if (cs_fall) begin
            fall_cnt     <= '0;
            wide_q       <= wide_sel;
            dout         <= 1'b0;
            dout_oe      <= 1'b1;
            sample_pulse <= 1'b0;
        end else begin
            sample_pulse <= sar_start;
            if (state != ST_DOWN && sck_fall) begin
                fall_cnt <= fall_nxt;
                dout     <= sar_step ? cmp_in : 1'b0;
            end
        end
    end

    AST_OE_ON_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        cs_fall |=> (dout_oe && !dout)); // R2
    AST_ABORT_TO_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        cs_rise |=> (state == ST_DOWN && !conv_busy && !dout_oe)); // R8
    AST_BUSY_WITH_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(conv_busy) |-> sample_pulse); // R4
    AST_STROBES_APART: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({chan_load, sample_pulse})); // R4
    AST_FLUSH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FLUSH && sck_fall && !cs_rise) |=> !dout); // R7
    AST_CFG_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DOWN && !cs_fall) |=> $stable(cfg_word)); // R9
    AST_EXT_REF_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_word[2:1] == 2'b11) |-> (!ref_on && !buf_on)); // R10

endmodule

// File: tb/sar_cmd_frontend_tb.sv
`timescale 1ns/1ps
module sar_cmd_frontend_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b0;
    logic        din = 1'b0;
    logic        wide_sel = 1'b0;
    logic        cmp_in;
    logic        dout, dout_oe, chan_load, sample_pulse, conv_busy, ref_on, buf_on;
    logic [2:0]  chan_sel;
    logic [15:0] trial;
    logic [7:0]  cfg_word;
    logic [15:0] code = 16'h0000;

    int    total = 0;
    int    bad = 0;
    bit    finished = 0;
    string scen = "reset";

    always #2 clk = ~clk;

    assign cmp_in = (code >= trial);

    sar_cmd_frontend u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
        .wide_sel(wide_sel), .cmp_in(cmp_in), .dout(dout), .dout_oe(dout_oe),
        .chan_sel(chan_sel), .chan_load(chan_load), .sample_pulse(sample_pulse),
        .conv_busy(conv_busy), .trial(trial), .cfg_word(cfg_word),
        .ref_on(ref_on), .buf_on(buf_on)
    );

    // Behavioural reference model
    int          m_active, m_rise, m_fall, m_wide;
    logic        m_csp, m_skp;
    logic [7:0]  m_sh, m_cfg;
    logic [2:0]  m_chan;
    logic        m_chanp, m_sampp, m_busy, m_dout, m_oe, m_ref, m_buf;
    string       m_dtag;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_active = 0; m_rise = 0; m_fall = 0; m_wide = 0;
            m_csp = 1'b1; m_skp = 1'b0; m_sh = 8'h00; m_cfg = 8'h06;
            m_chan = 3'd0; m_chanp = 0; m_sampp = 0; m_busy = 0;
            m_dout = 0; m_oe = 0; m_dtag = "R1";
        end else begin
            int start_f;
            m_chanp = 0;
            m_sampp = 0;
            if (cs_n && !m_csp) begin
                m_active = 0; m_oe = 0; m_dout = 0; m_busy = 0; m_dtag = "R8";
            end else if (!cs_n && m_csp) begin
                m_active = 1; m_oe = 1; m_dout = 0; m_rise = 0; m_fall = 0;
                m_wide = int'(wide_sel); m_dtag = "R2";
            end else if (m_active != 0) begin
                if (sclk && !m_skp) begin
                    m_rise++;
                    if (m_rise <= 8) m_sh = {m_sh[6:0], din};
                    if (m_rise == 3) begin m_chan = m_sh[2:0]; m_chanp = 1; end
                    if (m_rise == 8) m_cfg = m_sh;
                end
                if (!sclk && m_skp) begin
                    m_fall++;
                    start_f = (m_wide != 0) ? 16 : 8;
                    if (m_fall == start_f - 2) begin m_sampp = 1; m_busy = 1; end
                    if (m_fall >= start_f && m_fall <= start_f + 15) begin
                        m_dout = code[15 - (m_fall - start_f)];
                        m_dtag = "R5";
                        if (m_fall == start_f + 15) m_busy = 0;
                    end else begin
                        m_dout = 0;
                        m_dtag = (m_fall < start_f) ? "R6" : "R7";
                    end
                end
            end
            m_csp = cs_n;
            m_skp = sclk;
        end
        if (m_active != 0) begin
            m_ref = (m_cfg[2:1] != 2'b11);
            m_buf = (m_cfg[2:1] != 2'b11);
        end else begin
            m_ref = (m_cfg[2:1] == 2'b00) || (m_cfg[2:1] == 2'b10);
            m_buf = (m_cfg[2:1] == 2'b00);
        end
    end

    task automatic check(input string tag, input string name,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s [%s] %s: actual %0h expected %0h", tag, scen, name, act, exp);
        end
    endtask

    // Cycle-by-cycle comparison
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check(m_dtag, "dout", 32'(dout), 32'(m_dout));
            check("R2", "dout_oe", 32'(dout_oe), 32'(m_oe));
            check("R3", "chan_sel", 32'(chan_sel), 32'(m_chan));
            check("R3", "chan_load", 32'(chan_load), 32'(m_chanp));
            check("R4", "sample_pulse", 32'(sample_pulse), 32'(m_sampp));
            check("R4", "conv_busy", 32'(conv_busy), 32'(m_busy));
            check("R9", "cfg_word", 32'(cfg_word), 32'(m_cfg));
            check("R10", "ref_on", 32'(ref_on), 32'(m_ref));
            check("R10", "buf_on", 32'(buf_on), 32'(m_buf));
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xfer(input logic [7:0] cmd, input int nclk, input logic ws,
                        input logic [15:0] val, input bit flip);
        code = val;
        wide_sel = ws;
        step(1);
        cs_n = 1'b0;
        step(3);
        if (flip) wide_sel = ~ws;
        for (int i = 1; i <= nclk; i++) begin
            din = (i <= 8) ? cmd[8 - i] : i[0];
            step(2);
            sclk = 1'b1;
            step(2);
            sclk = 1'b0;
        end
        step(3);
        cs_n = 1'b1;
        step(4);
        wide_sel = ws;
    endtask

    initial begin
        step(5);
        rst_n = 1'b1;
        step(1);
        check("R1", "cfg after reset", 32'(cfg_word), 32'h06);
        check("R1", "chan after reset", 32'(chan_sel), 32'h0);
        check("R1", "oe after reset", 32'(dout_oe), 32'h0);
        check("R1", "ref/buf after reset", 32'({ref_on, buf_on}), 32'h0);

        scen = "short frame, pad clocks, R7";
        xfer(8'hA0, 26, 1'b0, 16'hA5C3, 1'b0);
        check("R10", "down 00", 32'({ref_on, buf_on}), 32'h3);

        scen = "long frame";
        xfer(8'h62, 34, 1'b1, 16'h1234, 1'b0);
        check("R10", "down 01", 32'({ref_on, buf_on}), 32'h0);

        scen = "short frame all ones";
        xfer(8'hCC, 24, 1'b0, 16'hFFFF, 1'b0);
        check("R10", "down 10", 32'({ref_on, buf_on}), 32'h2);
        check("R9", "cfg commit", 32'(cfg_word), 32'hCC);

        scen = "abort mid conversion R8";
        xfer(8'h26, 12, 1'b0, 16'h0001, 1'b0);
        check("R8", "busy after abort", 32'(conv_busy), 32'h0);
        check("R10", "down 11", 32'({ref_on, buf_on}), 32'h0);

        scen = "partial command R9";
        xfer(8'hE0, 5, 1'b0, 16'h7777, 1'b0);
        check("R9", "cfg unchanged", 32'(cfg_word), 32'h26);

        scen = "width toggled mid frame R11";
        xfer(8'h40, 34, 1'b1, 16'h8000, 1'b1);

        scen = "short frame zero code";
        xfer(8'h1A, 24, 1'b0, 16'h0000, 1'b0);

        scen = "long frame abort in shift R8";
        xfer(8'hF4, 20, 1'b1, 16'h5555, 1'b0);
        check("R10", "down after long abort", 32'({ref_on, buf_on}), 32'h2);

        scen = "short alternating code";
        xfer(8'h82, 24, 1'b0, 16'hAAAA, 1'b0);

        step(4);
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog: actual expired expected finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule